// File: doc/BRIEF.md
# Input-State Serial Reporter with Parity

This block is a serial-peripheral slave that reports eight input states and a few status bits to a host controller. The host uses clock polarity 0 and phase 0. The host pulls chip select low. At that moment the block takes a snapshot of the inputs, the two alarm flags and four parity bits, and places the snapshot in a shift register. The first bit of the snapshot is driven on the data output straight away. On each rising serial-clock edge the block samples the host data line. On each falling edge the register moves one place toward the output. A second output always carries the complement of the data output.

The serial clock, chip select and host data line are resynchronised into a much faster system clock, and their edges are found in that clock domain. A mode input picks a short frame that holds only the eight inputs, or a long frame of sixteen bits. The bits shifted in from the host line come out behind the frame, so several devices can be chained in a row. A power-good input holds the data output low during a transfer when power is lost. A host can then spot the loss because the last stop bit reads 0.

Top module: `instate_spi_reporter`

## Requirements
- R1: On the falling edge of chip select, the frame is loaded. Its first bit (input 8) is on `miso` before the first rising serial-clock edge, with `miso_oe` = 1.
- R2: The long frame (`frame16` = 1) comes out in this order, first bit to last: inputs 8 down to 1, under-voltage bit, over-temperature bit, P1, P2, P3, P4, a 0 stop bit, then a 1 stop bit.
- R3: The alarm bits are active low. `uv_alarm` = 1 sends a 0 in the under-voltage position, and `ot_alarm` = 1 sends a 0 in the over-temperature position.
- R4: Pk is the XNOR of input k and input k+4, for k = 1..4. Inputs 8..1 = 1,0,0,1,1,0,0,1 give P1..P4 = 1,1,1,1.
- R5: With `frame16` = 0, the frame is only inputs 8 down to 1. After those 8 bits, the host bits shifted in come out in the order they were sent.
- R6: While chip select is high, `miso_oe` is 0 and both outputs count as high impedance.
- R7: While `pwr_good` = 0 and chip select is low, `miso` = 0 and `miso_n` = 1.
- R8: While `pwr_good` = 1 and chip select is low, `miso_n` is the complement of `miso`.
- R9: In long mode, after 16 clocks the host bits come out in order. Extra clocks keep shifting and never reload until chip select rises.
- R10: A change on the inputs or alarms after chip select has fallen does not alter the frame of that transfer.
- R11: After reset, `miso_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select from host, active low |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Data from host or from the previous device in the chain |
| frame16 | input | 1 | 1 selects the 16-bit frame, 0 the 8-bit frame |
| pwr_good | input | 1 | 1 means supply is good |
| in_state | input | 8 | Filtered input states, bit 0 is input 1 |
| uv_alarm | input | 1 | Under-voltage alarm, active high |
| ot_alarm | input | 1 | Over-temperature alarm, active high |
| miso | output | 1 | Serial data to host |
| miso_n | output | 1 | Complement of `miso` |
| miso_oe | output | 1 | 1 when both outputs are driven, 0 for high impedance |

## Verification
A wrong shift register can only show up on `miso`. A bad load or a wrong bit position changes the sampled frame within the first transfer after the fault. A missed or doubled shift moves every later bit by one place, so it is caught in the same frame. A fault in host-data capture or in the short-mode insert point only appears in the bits after the frame, so the bench runs over-long transfers in both modes. Faults in the output-enable and power-loss paths show on `miso_oe`, `miso` and `miso_n` three system clocks after chip select moves.

// File: rtl/instate_pkg.sv
package instate_pkg;
    localparam int NUM_IN  = 8;
    localparam int NUM_PAR = NUM_IN / 2;
    localparam int FRAME_W = NUM_IN + NUM_PAR + 4;

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic               mosi_cap;
        logic               short_mode;
        logic               oe;
        logic               cs_p;
        logic               sck_p;
    } shift_state_t;
endpackage

// File: rtl/instate_sync.sv
module instate_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/instate_framer.sv
module instate_framer
    import instate_pkg::*;
(
    input  logic [NUM_IN-1:0]  in_state,
    input  logic               uv_alarm,
    input  logic               ot_alarm,
    output logic [FRAME_W-1:0] frame_o
);
    logic [NUM_PAR-1:0] par;

    generate
        for (genvar k = 0; k < NUM_PAR; k++) begin : g_par
            assign par[k] = ~(in_state[k] ^ in_state[k+NUM_PAR]);
        end
    endgenerate

    logic [NUM_PAR-1:0] par_rev;
    always_comb begin
        for (int k = 0; k < NUM_PAR; k++) begin
            par_rev[NUM_PAR-1-k] = par[k];
        end
    end

    assign frame_o = {in_state, ~uv_alarm, ~ot_alarm, par_rev, 1'b0, 1'b1};
endmodule

// File: rtl/instate_shifter.sv
module instate_shifter
    import instate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_s,
    input  logic               sck_s,
    input  logic               mosi_s,
    input  logic               short_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               data_o,
    output logic               oe_o
);
    localparam int LOW_W = FRAME_W - NUM_IN;

    shift_state_t st_d, st_q;
    logic cs_fall, sck_rise, sck_fall;

    always_comb begin
        st_d     = st_q;
        cs_fall  = st_q.cs_p & ~cs_s;
        sck_rise = ~st_q.sck_p & sck_s & ~cs_s;
        sck_fall = st_q.sck_p & ~sck_s & ~cs_s;
        st_d.cs_p  = cs_s;
        st_d.sck_p = sck_s;
        st_d.oe    = ~cs_s;
        if (cs_fall) begin
            st_d.shreg      = frame_i;
            st_d.short_mode = short_i;
        end else if (sck_rise) begin
            st_d.mosi_cap = mosi_s;
        end else if (sck_fall) begin
            if (st_q.short_mode) begin
                st_d.shreg[FRAME_W-1:LOW_W] = {st_q.shreg[FRAME_W-2:LOW_W], st_q.mosi_cap};
            end else begin
                st_d.shreg = {st_q.shreg[FRAME_W-2:0], st_q.mosi_cap};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cs_p  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.shreg[FRAME_W-1];
    assign oe_o   = st_q.oe;

    // R1
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (st_q.shreg == $past(frame_i)) && oe_o);

    // R9
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_fall && !cs_fall && !st_q.short_mode) |=>
            (st_q.shreg[FRAME_W-1:1] == $past(st_q.shreg[FRAME_W-2:0]))
            && (st_q.shreg[0] == $past(st_q.mosi_cap)));

    // R5
    short_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_fall && !cs_fall && st_q.short_mode) |=> $stable(st_q.shreg[LOW_W-1:0]));

    // R6
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !oe_o);
endmodule

// File: rtl/instate_spi_reporter.sv
module instate_spi_reporter
    import instate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              frame16,
    input  logic              pwr_good,
    input  logic [NUM_IN-1:0] in_state,
    input  logic              uv_alarm,
    input  logic              ot_alarm,
    output logic              miso,
    output logic              miso_n,
    output logic              miso_oe
);
    logic [2:0]         pins_s;
    logic [FRAME_W-1:0] frame;
    logic               sh_data;

    instate_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({cs_n, sck, mosi}),
        .sync_o (pins_s)
    );

    instate_framer framer_i (
        .in_state(in_state),
        .uv_alarm(uv_alarm),
        .ot_alarm(ot_alarm),
        .frame_o (frame)
    );

    instate_shifter shifter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_s   (pins_s[2]),
        .sck_s  (pins_s[1]),
        .mosi_s (pins_s[0]),
        .short_i(~frame16),
        .frame_i(frame),
        .data_o (sh_data),
        .oe_o   (miso_oe)
    );

    assign miso   = pwr_good & sh_data;
    assign miso_n = ~miso;

    // R7
    pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good && miso_oe) |-> (!miso && miso_n));
endmodule

// File: tb/instate_spi_reporter_tb.sv
module instate_spi_reporter_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       cs_n = 1, sck = 0, mosi = 0, frame16 = 1, pwr_good = 1;
    logic [7:0] in_state = 0;
    logic       uv_alarm = 0, ot_alarm = 0;
    logic       miso, miso_n, miso_oe;

    int checks = 0, errors = 0;
    logic [31:0] rx;
    logic        comp_bad, oe_bad;
    logic        mid_change = 0;

    always #2 clk = ~clk;

    instate_spi_reporter dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .frame16(frame16), .pwr_good(pwr_good), .in_state(in_state),
        .uv_alarm(uv_alarm), .ot_alarm(ot_alarm),
        .miso(miso), .miso_n(miso_n), .miso_oe(miso_oe)
    );

    function automatic logic [15:0] exp_frame(logic [7:0] d, logic uv, logic ot);
        return {d, ~uv, ~ot, ~(d[0]^d[4]), ~(d[1]^d[5]), ~(d[2]^d[6]), ~(d[3]^d[7]), 1'b0, 1'b1};
    endfunction

    task automatic wclk(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(int n, logic [31:0] tx);
        comp_bad = 0;
        oe_bad   = 0;
        rx       = 0;
        cs_n = 0;
        wclk(8);
        for (int i = 0; i < n; i++) begin
            mosi = tx[n-1-i];
            wclk(8);
            rx = {rx[30:0], miso};
            if (miso_n !== ~miso) comp_bad = 1;
            if (miso_oe !== 1'b1) oe_bad = 1;
            sck = 1;
            wclk(8);
            if (mid_change && i == 3) begin
                in_state = ~in_state;
                uv_alarm = ~uv_alarm;
            end
            sck = 0;
            wclk(8);
        end
        cs_n = 1;
        wclk(8);
    endtask

    localparam int NV = 6;
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 8'b1001_1001},
        {1'b1, 1'b1, 1'b0, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'hFF},
        {1'b1, 1'b1, 1'b1, 8'h5A},
        {1'b0, 1'b1, 1'b0, 8'hC3},
        {1'b0, 1'b0, 1'b1, 8'h81}
    };

    initial begin
        wclk(3);
        rst_n = 1;
        wclk(4);
        chk("R11 reset oe", {31'd0, miso_oe}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            frame16  = VEC[v][10];
            uv_alarm = VEC[v][9];
            ot_alarm = VEC[v][8];
            in_state = VEC[v][7:0];
            if (frame16) begin
                xfer(16, 0);
                chk("R2 R3 R4 long frame", {16'd0, rx[15:0]},
                    {16'd0, exp_frame(in_state, uv_alarm, ot_alarm)});
            end else begin
                xfer(8, 0);
                chk("R5 short frame", {24'd0, rx[7:0]}, {24'd0, in_state});
            end
            chk("R8 complement", {31'd0, comp_bad}, 32'd0);
        end

        chk("R4 parity example", {28'd0, exp_frame(8'b1001_1001, 0, 0)[5:2]}, 32'hF);

        frame16 = 1; in_state = 8'hA5; uv_alarm = 0; ot_alarm = 0;
        cs_n = 0;
        wclk(8);
        chk("R1 first bit before clock", {30'd0, miso_oe, miso}, {30'd0, 1'b1, 1'b1});
        cs_n = 1;
        wclk(8);
        chk("R6 idle oe", {31'd0, miso_oe}, 32'd0);

        xfer(32, 32'h1234_BEEF);
        chk("R9 chain long", rx, {exp_frame(8'hA5, 0, 0), 16'h1234});
        chk("R1 oe during frame", {31'd0, oe_bad}, 32'd0);
        chk("R6 oe after frame", {31'd0, miso_oe}, 32'd0);

        frame16 = 0; in_state = 8'h3C;
        xfer(16, 32'h0000_D700);
        chk("R5 chain short", {16'd0, rx[15:0]}, {16'd0, 8'h3C, 8'hD7});

        frame16 = 1; in_state = 8'h96; uv_alarm = 0; ot_alarm = 0;
        mid_change = 1;
        xfer(16, 0);
        mid_change = 0;
        chk("R10 snapshot", {16'd0, rx[15:0]}, {16'd0, exp_frame(8'h96, 0, 0)});

        pwr_good = 0; in_state = 8'hFF;
        xfer(16, 32'hFFFF);
        chk("R7 power loss data", {16'd0, rx[15:0]}, 32'd0);
        chk("R7 power loss complement", {31'd0, comp_bad}, 32'd0);
        cs_n = 0;
        wclk(8);
        chk("R7 stop bit low, inverse high", {29'd0, miso_oe, miso, miso_n}, {29'd0, 3'b101});
        cs_n = 1;
        wclk(8);
        pwr_good = 1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule